// File: doc/BRIEF.md
# Delayed Tight Sub-Clock Monitor

This block watches two logical clocks that share one system clock: a reference tick and a sub tick. Each signal is sampled as a level on every rising edge of the system clock. Every cycle in which a signal is sampled high counts as one event of that signal, so a line held high for three cycles gives three events. The two clocks may tick at any spacing of one or more system cycles.

The monitor enforces a lagged tight sub-clock relation. The first `LAG` reference events must pass with no sub tick. From reference event `LAG+1` onward, every reference event must carry a sub tick in the same cycle. A sub tick in a cycle without a reference tick is wrong at any time.

Any breach of these rules raises a one-cycle violation pulse in the cycle after the offending sample. It also sets an error flag that stays set until reset. The monitor also reports how many reference events it has counted, saturating at `LAG`, and a flag showing that the tight phase is active.

Top module: `subclk_lag_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `ref_index_o` = 0, `viol_o` = 0 and `err_o` = 0.
- R2: Each cycle in which `ref_tick_i` is sampled high while `ref_index_o` < `LAG` raises `ref_index_o` by one after that edge. A reference tick held high for several cycles counts once per cycle. Once `ref_index_o` reaches `LAG` it holds there, and a cycle with `ref_tick_i` low leaves it unchanged.
- R3: A sample with `sub_tick_i` high and `ref_tick_i` low makes `viol_o` 1 in the following cycle, in any phase.
- R4: A sample with both ticks high while `ref_index_o` < `LAG` makes `viol_o` 1 in the following cycle. With `LAG` = 5, a sub tick on the 3rd reference event is illegal.
- R5: A sample with `ref_tick_i` high and `sub_tick_i` low while `ref_index_o` = `LAG` makes `viol_o` 1 in the following cycle.
- R6: These samples make `viol_o` 0 in the following cycle: both ticks high while `ref_index_o` = `LAG`, both ticks low, and a reference tick alone while `ref_index_o` < `LAG`.
- R7: `viol_o` is a registered pulse for one sample only. A legal sample that follows an offending one returns it to 0.
- R8: `err_o` becomes 1 in the same cycle as the first `viol_o` pulse. It stays 1 until reset.
- R9: `tight_o` is 1 exactly when `ref_index_o` = `LAG`. Once it is 1, it stays 1 until reset.
- R10: With `LAG` = 0, `tight_o` is 1 straight after reset, and the rule of R5 applies from the first reference event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both ticks are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick_i | input | 1 | Reference logical clock, sampled as a level |
| sub_tick_i | input | 1 | Sub logical clock, sampled as a level |
| viol_o | output | 1 | One-cycle pulse for a rule breach in the previous sample |
| err_o | output | 1 | Sticky error flag, set by any breach |
| ref_index_o | output | CNT_W | Reference events counted, saturating at LAG |
| tight_o | output | 1 | High once LAG reference events have been seen |

## Verification
Every output is one register away from the inputs. The sample taken at edge n therefore shows on `viol_o`, `err_o`, `ref_index_o` and `tight_o` just after edge n, and the pulse clears after edge n+1 if that sample is legal. The bench changes the ticks on the falling edge. It waits for the next rising edge and reads the outputs one nanosecond later, so each check sees exactly the result of the sample it names. The `LAG` = 0 case uses a second instance that is driven with the same ticks.

// File: rtl/subclk_pkg.sv
package subclk_pkg;

    // Rule breaches found in one sample
    typedef struct packed {
        logic stray;    // sub tick with no reference tick
        logic early;    // sub tick before the tight phase
        logic missing;  // reference tick without sub tick in the tight phase
    } breach_t;

    // Registered flags of the monitor
    typedef struct packed {
        logic viol;
        logic err;
    } flag_t;

    function automatic int unsigned idx_width(input int unsigned lag);
        return (lag < 1) ? 1 : $clog2(lag + 1);
    endfunction

endpackage

// File: rtl/subclk_index_ctr.sv
module subclk_index_ctr #(
    parameter int unsigned LAG   = 5,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    output logic [CNT_W-1:0] idx_o,
    output logic             full_o
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(LAG);

    typedef struct packed {
        logic [CNT_W-1:0] idx;
    } ctr_t;

    ctr_t st_d, st_q;
    logic at_top;

    assign at_top = (st_q.idx == TOP);

    always_comb begin
        st_d = st_q;
        if (adv_i && !at_top) begin
            st_d.idx = st_q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o  = st_q.idx;
    assign full_o = at_top;

endmodule

// File: rtl/subclk_rule_eval.sv
module subclk_rule_eval
    import subclk_pkg::*;
(
    input  logic    ref_i,
    input  logic    sub_i,
    input  logic    tight_i,
    output breach_t breach_o
);

    always_comb begin
        breach_o         = '0;
        breach_o.stray   = sub_i && !ref_i;
        breach_o.early   = sub_i && ref_i && !tight_i;
        breach_o.missing = ref_i && !sub_i && tight_i;
    end

endmodule

// File: rtl/subclk_flag_reg.sv
module subclk_flag_reg
    import subclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  breach_t breach_i,
    output logic    viol_o,
    output logic    err_o
);

    flag_t fl_d, fl_q;
    logic  any_breach;

    assign any_breach = |breach_i;

    always_comb begin
        fl_d      = fl_q;
        fl_d.viol = any_breach;
        fl_d.err  = fl_q.err || any_breach;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign viol_o = fl_q.viol;
    assign err_o  = fl_q.err;

endmodule

// File: rtl/subclk_lag_monitor.sv
module subclk_lag_monitor
    import subclk_pkg::*;
#(
    parameter int unsigned LAG   = 5,
    parameter int unsigned CNT_W = idx_width(LAG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick_i,
    input  logic             sub_tick_i,
    output logic             viol_o,
    output logic             err_o,
    output logic [CNT_W-1:0] ref_index_o,
    output logic             tight_o
);

    logic    tight;
    breach_t breach;

    subclk_index_ctr #(
        .LAG   (LAG),
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (ref_tick_i),
        .idx_o  (ref_index_o),
        .full_o (tight)
    );

    subclk_rule_eval u_rule (
        .ref_i    (ref_tick_i),
        .sub_i    (sub_tick_i),
        .tight_i  (tight),
        .breach_o (breach)
    );

    subclk_flag_reg u_flags (
        .clk      (clk),
        .rst      (rst),
        .breach_i (breach),
        .viol_o   (viol_o),
        .err_o    (err_o)
    );

    assign tight_o = tight;

endmodule

// File: rtl/subclk_lag_monitor_chk.sv
module subclk_lag_monitor_chk #(
    parameter int unsigned LAG   = 5,
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_tick_i,
    input logic             sub_tick_i,
    input logic             viol_o,
    input logic             err_o,
    input logic [CNT_W-1:0] ref_index_o,
    input logic             tight_o
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(LAG);

    // R2
    index_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_tick_i && ref_index_o != TOP) |=> ref_index_o == $past(ref_index_o) + CNT_W'(1));

    // R2
    index_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_tick_i || ref_index_o == TOP) |=> $stable(ref_index_o));

    // R3
    stray_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_tick_i && !ref_tick_i) |=> viol_o);

    // R4
    early_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (sub_tick_i && ref_tick_i && ref_index_o != TOP) |=> viol_o);

    // R5
    missing_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_tick_i && !sub_tick_i && ref_index_o == TOP) |=> viol_o);

    // R6
    legal_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_tick_i && sub_tick_i && ref_index_o == TOP) |=> !viol_o);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_tick_i && !sub_tick_i) |=> !viol_o);

    // R8
    err_cover_chk: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> err_o);

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R9
    tight_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tight_o |=> tight_o);

endmodule

bind subclk_lag_monitor subclk_lag_monitor_chk #(
    .LAG   (LAG),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_tick_i  (ref_tick_i),
    .sub_tick_i  (sub_tick_i),
    .viol_o      (viol_o),
    .err_o       (err_o),
    .ref_index_o (ref_index_o),
    .tight_o     (tight_o)
);

// File: tb/subclk_lag_monitor_test.sv
`timescale 1ns/1ps
module subclk_lag_monitor_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a   = 1'b0;
    logic       o   = 1'b0;
    logic       viol, err, tight;
    logic [2:0] idx;
    logic       viol0, err0, tight0;
    logic [0:0] idx0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    subclk_lag_monitor #(.LAG(5)) uut (
        .clk(clk), .rst(rst), .ref_tick_i(a), .sub_tick_i(o),
        .viol_o(viol), .err_o(err), .ref_index_o(idx), .tight_o(tight)
    );

    subclk_lag_monitor #(.LAG(0)) uut0 (
        .clk(clk), .rst(rst), .ref_tick_i(a), .sub_tick_i(o),
        .viol_o(viol0), .err_o(err0), .ref_index_o(idx0), .tight_o(tight0)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one sample, then read the outputs just after the edge that takes it
    task automatic step(input logic av, input logic ov);
        @(negedge clk);
        a = av;
        o = ov;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        a   = 1'b0;
        o   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        check("R1", "index after reset", idx, 0);
        check("R1", "viol after reset", viol, 0);
        check("R1", "err after reset", err, 0);
        check("R9", "tight after reset", tight, 0);
    endtask

    task automatic t_level_count();
        do_reset();
        step(1, 0); step(1, 0); step(1, 0);
        check("R2", "held tick counts per cycle", idx, 3);
        check("R6", "lone ref before tight is legal", viol, 0);
        step(0, 0);
        check("R2", "index holds without tick", idx, 3);
        check("R9", "not tight at 3", tight, 0);
    endtask

    task automatic t_stray();
        do_reset();
        step(0, 1);
        check("R3", "sub without ref", viol, 1);
        check("R2", "index untouched by stray", idx, 0);
        check("R8", "err set with first pulse", err, 1);
        step(0, 0);
        check("R7", "pulse clears", viol, 0);
        check("R8", "err stays", err, 1);
    endtask

    task automatic t_early();
        do_reset();
        step(1, 0); step(0, 0); step(1, 0);
        check("R6", "no viol yet", viol, 0);
        step(1, 1);
        check("R4", "sub on 3rd ref event", viol, 1);
        check("R2", "index counts early event", idx, 3);
        step(0, 0);
        check("R7", "pulse lasts one cycle", viol, 0);
        check("R8", "err sticky", err, 1);
    endtask

    task automatic t_tight();
        do_reset();
        for (int i = 0; i < 5; i++) begin
            step(1, 0);
            step(0, 0);
        end
        check("R9", "tight after 5 events", tight, 1);
        check("R2", "index at LAG", idx, 5);
        check("R6", "no err in warm-up", err, 0);
        step(1, 1);
        check("R6", "paired tick legal", viol, 0);
        check("R2", "index saturates", idx, 5);
        step(1, 1);
        check("R6", "back-to-back pair legal", viol, 0);
        step(1, 0);
        check("R5", "ref without sub in tight phase", viol, 1);
        step(1, 1);
        check("R7", "pulse clears on legal pair", viol, 0);
        check("R9", "tight stays", tight, 1);
        step(0, 1);
        check("R3", "stray in tight phase", viol, 1);
    endtask

    task automatic t_mid_reset();
        step(0, 1);
        do_reset();
        #1;
        check("R1", "err cleared by reset", err, 0);
        check("R1", "index cleared by reset", idx, 0);
        check("R1", "viol cleared by reset", viol, 0);
    endtask

    task automatic t_lag_zero();
        do_reset();
        #1;
        check("R10", "tight at once with LAG 0", tight0, 1);
        step(1, 1);
        check("R10", "pair legal from first event", viol0, 0);
        check("R4", "same pair early for LAG 5", viol, 1);
        step(1, 0);
        check("R10", "first phase missing sub", viol0, 1);
        check("R10", "index stays 0", idx0, 0);
    endtask

    initial begin
        t_reset();
        t_level_count();
        t_stray();
        t_early();
        t_tight();
        t_mid_reset();
        t_lag_zero();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule